// File: doc/BRIEF.md
# Power-Mode Special-Cycle Broadcaster

This block is a small PCI bus master. When the host is about to enter a low-power state, it tells every agent on the bus. A one-clock pulse on `nap_req` or `sleep_req` selects which broadcast messages are owed. Two enable bits can suppress each message. For every message that remains, the block requests the bus, waits for grant, and drives one address phase carrying the special-cycle command. It then drives one data phase. The 16-bit message code goes in the low half of AD, and a caller-supplied data word goes in the high half.

No target claims a special cycle. Each transaction therefore runs until a fixed DEVSEL window expires and ends by master-abort. This abort never touches the received-master-abort status flag. That flag is kept here so that aborts reported from the chip's other master paths still set it.

Entering sleep owes a SHUTDOWN message (code 0x0000) followed by a HALT message (code 0x0001). Entering nap owes only HALT. Each message is its own arbitrated transaction. `done` pulses once after the last owed message, or right away when nothing was owed. Requests are sampled only while the block is idle.

Top module: `pm_scyc_bcast`

## Requirements
- R1: During and directly after reset, `req_n`, `frame_n` and `irdy_n` are high, and `ad_oe`, `done` and `rma_sts` are low.
- R2: A sleep request with both enables set produces two transactions, each with its own bus request. The first carries code 0x0000 and the second carries code 0x0001, and both carry `msg_data` (latched at the request) in AD[31:16].
- R3: A nap request with the HALT enable set produces exactly one transaction, carrying code 0x0001.
- R4: A message whose enable bit is low produces no bus cycle. If no message is owed, `done` is high on the clock after the request is sampled and the bus request stays high.
- R5: The address phase lasts one clock and begins on the clock after `gnt_n` is sampled low while requesting. In it, `frame_n` is low, `irdy_n` is high, `cbe_n` is 4'b0001 and AD is all zero.
- R6: `irdy_n` first goes low WAIT_STATES clocks after the address phase. While `irdy_n` is low, `cbe_n` is 4'b0000 and AD holds {data, code} without change.
- R7: With DEVSEL never asserted, `frame_n` stays low for 1+DEVSEL_TO clocks. It then rises while `irdy_n` stays low for one more clock. On the clock after that, `irdy_n` is high and `ad_oe` is low.
- R8: A special-cycle master-abort never sets `rma_sts`. A pulse on `mabort_other` sets it, and `rma_clr` clears it, with clear taking precedence.
- R9: `done` is a one-clock pulse, high on the clock after the final transaction's last IRDY clock. It is low after any earlier transaction.
- R10: While `irdy_n` is low, AD[15:0] is only ever 0x0000 or 0x0001.
- R11: If DEVSEL is sampled low while `irdy_n` is low, `frame_n` rises on the next clock with the same one-clock IRDY tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nap_req | input | 1 | Pulse: host entering nap (sampled while idle) |
| sleep_req | input | 1 | Pulse: host entering sleep (sampled while idle) |
| en_shutdown | input | 1 | Allows the SHUTDOWN broadcast |
| en_halt | input | 1 | Allows the HALT broadcast |
| msg_data | input | 16 | Optional data word, latched at the request |
| gnt_n | input | 1 | Bus grant from the arbiter, active low |
| devsel_n | input | 1 | Target select from the bus, active low |
| mabort_other | input | 1 | Master-abort seen on a non-special cycle |
| rma_clr | input | 1 | Clears the received-master-abort flag |
| req_n | output | 1 | Bus request, active low |
| frame_n | output | 1 | FRAME, active low |
| irdy_n | output | 1 | IRDY, active low |
| cbe_n | output | 4 | Command / byte enables |
| ad | output | 32 | Address/data value |
| ad_oe | output | 1 | Drive enable for AD and C/BE |
| done | output | 1 | One-clock completion pulse |
| rma_sts | output | 1 | Received-master-abort status flag |

## Verification
The scoreboard checks message order for a sleep entry: SHUTDOWN must come before HALT, each behind its own request and grant. A design that merged the two into one transaction, or swapped them, fails the code comparison or the request count. Each enable mix is tried, including the case where everything is masked. A design that still ran a cycle with a masked message would pop an item that was never expected, and one that forgot to raise `done` would stall.

The FRAME length is measured with and without a responding target. This catches a timeout that is off by one and a design that ignores DEVSEL. The clock after FRAME rises is checked to catch a missing IRDY tail. The status flag is checked after every broadcast, to catch a design that sets it on a special-cycle abort.

// File: rtl/pm_scyc_bcast.sv
module pm_scyc_bcast #(
  parameter int WAIT_STATES = 1,
  parameter int DEVSEL_TO   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nap_req,
  input  logic        sleep_req,
  input  logic        en_shutdown,
  input  logic        en_halt,
  input  logic [15:0] msg_data,
  input  logic        gnt_n,
  input  logic        devsel_n,
  input  logic        mabort_other,
  input  logic        rma_clr,
  output logic        req_n,
  output logic        frame_n,
  output logic        irdy_n,
  output logic [3:0]  cbe_n,
  output logic [31:0] ad,
  output logic        ad_oe,
  output logic        done,
  output logic        rma_sts
);

  localparam int CW = $clog2(DEVSEL_TO + 2);
  localparam logic [3:0]  CMD_SPECIAL = 4'b0001;
  localparam logic [15:0] CODE_SHUT   = 16'h0000;
  localparam logic [15:0] CODE_HALT   = 16'h0001;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_LAST} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          sd_pend, ht_pend;
  logic [15:0]   data_q;

  wire any_req  = sleep_req | nap_req;
  wire want_sd  = sleep_req & en_shutdown;
  wire want_ht  = any_req & en_halt;
  wire start    = (st == S_IDLE) & (want_sd | want_ht);
  wire none     = (st == S_IDLE) & any_req & ~(want_sd | want_ht);
  wire more     = sd_pend & ht_pend;
  wire in_data  = (st == S_DATA) | (st == S_LAST);
  wire [15:0] code = sd_pend ? CODE_SHUT : CODE_HALT;

  assign req_n   = ~(st == S_REQ);
  assign frame_n = ~((st == S_ADDR) | (st == S_DATA));
  assign irdy_n  = ~(((st == S_DATA) & (cnt > CW'(WAIT_STATES))) | (st == S_LAST));
  assign ad_oe   = (st == S_ADDR) | in_data;
  assign cbe_n   = (st == S_ADDR) ? CMD_SPECIAL : 4'b0000;
  assign ad      = in_data ? {data_q, code} : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sd_pend <= 1'b0;
      ht_pend <= 1'b0;
      data_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= none | ((st == S_LAST) & ~more);
      case (st)
        S_IDLE: if (start) begin
          sd_pend <= want_sd;
          ht_pend <= want_ht;
          data_q  <= msg_data;
          st      <= S_REQ;
        end
        S_REQ:  if (!gnt_n) st <= S_ADDR;
        S_ADDR: begin
          cnt <= CW'(1);
          st  <= S_DATA;
        end
        S_DATA: begin
          cnt <= cnt + CW'(1);
          if ((!irdy_n && !devsel_n) || cnt == CW'(DEVSEL_TO)) st <= S_LAST;
        end
        S_LAST: begin
          if (sd_pend) sd_pend <= 1'b0;
          else         ht_pend <= 1'b0;
          st <= more ? S_REQ : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rma_sts <= 1'b0;
    else if (rma_clr)      rma_sts <= 1'b0;
    else if (mabort_other) rma_sts <= 1'b1;
  end

  AST_ADDR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> (cbe_n == CMD_SPECIAL && ad == 32'h0 && irdy_n)); // R5
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(!req_n && !gnt_n)); // R5
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !irdy_n |-> ad[15:1] == 15'h0); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && $past(!irdy_n)) |-> $stable(ad)); // R6
  AST_FRAME_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> !irdy_n); // R7
  AST_IRDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |=> (irdy_n && !ad_oe)); // R7
  AST_RMA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rma_sts) |-> $past(mabort_other)); // R8

endmodule

// File: tb/pm_scyc_bcast_tb.sv
module pm_scyc_bcast_tb_top;
  localparam int WS = 1;
  localparam int DT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nap_req = 0, sleep_req = 0, en_shutdown = 0, en_halt = 0;
  logic [15:0] msg_data = '0;
  logic gnt_n = 1'b1, devsel_n = 1'b1, mabort_other = 0, rma_clr = 0;
  logic req_n, frame_n, irdy_n, ad_oe, done, rma_sts;
  logic [3:0] cbe_n;
  logic [31:0] ad;

  always #5 clk = ~clk;

  pm_scyc_bcast #(.WAIT_STATES(WS), .DEVSEL_TO(DT)) dut_i (
    .clk(clk), .rst_n(rst_n), .nap_req(nap_req), .sleep_req(sleep_req),
    .en_shutdown(en_shutdown), .en_halt(en_halt), .msg_data(msg_data),
    .gnt_n(gnt_n), .devsel_n(devsel_n), .mabort_other(mabort_other),
    .rma_clr(rma_clr), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad(ad), .ad_oe(ad_oe), .done(done), .rma_sts(rma_sts));

  typedef struct packed { logic [15:0] data; logic [15:0] code; } item_t;
  item_t expq[$];
  int checks = 0, errors = 0;
  int req_falls = 0;
  bit devsel_en = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int gcnt = 0;
  always @(negedge clk) begin
    if (!rst_n || !frame_n || req_n) begin
      gnt_n <= 1'b1; gcnt <= 0;
    end else if (gcnt == 2) gnt_n <= 1'b0;
    else gcnt <= gcnt + 1;
    devsel_n <= !(devsel_en && !irdy_n && !frame_n);
  end

  logic prev_frame = 1'b1, prev_req = 1'b1;
  int flen = 0;
  bit got = 0, after_rise = 0;
  logic [31:0] cap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req && !req_n) req_falls++;
      if (after_rise) begin
        chk(irdy_n && !ad_oe, "R7 release after tail", {irdy_n, ad_oe}, 2'b10);
        chk(done == (expq.size() == 0), "R9 done after transaction", done, expq.size() == 0);
        after_rise = 0;
      end
      if (prev_frame && !frame_n) begin
        chk(cbe_n == 4'b0001 && ad == 0 && irdy_n, "R5 address phase", {cbe_n, ad[27:0]}, 32'h1000_0000);
        flen = 1; got = 0;
      end else if (!frame_n) flen++;
      if (!irdy_n && !got) begin
        item_t e;
        got = 1; cap = ad;
        chk(flen == WS + 2, "R6 irdy wait states", flen, WS + 2);
        chk(cbe_n == 4'b0000, "R6 byte enables", cbe_n, 0);
        chk(ad[15:1] == 0, "R10 legal code", ad[15:0], 1);
        if (expq.size() == 0) chk(0, "R4 unexpected transaction", ad, 0);
        else begin
          e = expq.pop_front();
          chk(ad == e, "R2 message content", ad, e);
        end
      end else if (!irdy_n) chk(ad == cap, "R6 data stable", ad, cap);
      if (!prev_frame && frame_n) begin
        chk(!irdy_n, "R7 irdy held at frame rise", irdy_n, 0);
        if (devsel_en) chk(flen == WS + 2, "R11 devsel early end", flen, WS + 2);
        else chk(flen == DT + 1, "R7 abort frame length", flen, DT + 1);
        after_rise = 1;
      end
    end
    prev_frame = frame_n;
    prev_req = req_n;
  end

  task automatic run_case(input bit nap, input bit slp, input bit esd, input bit eht,
                          input logic [15:0] d, input bit dsel, input string tag);
    int r0, nexp;
    bit seen;
    devsel_en = dsel; en_shutdown = esd; en_halt = eht; msg_data = d;
    nexp = 0;
    if (slp && esd) begin expq.push_back({d, 16'h0000}); nexp++; end
    if ((slp || nap) && eht) begin expq.push_back({d, 16'h0001}); nexp++; end
    r0 = req_falls;
    nap_req = nap; sleep_req = slp;
    @(negedge clk);
    nap_req = 0; sleep_req = 0; msg_data = 16'hFFFF;
    seen = done;
    if (nexp == 0) chk(done, {tag, " R4 immediate done"}, done, 1);
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      seen = done;
    end
    chk(seen, {tag, " R9 done seen"}, seen, 1);
    @(negedge clk);
    chk(!done, {tag, " R9 done one clock"}, done, 0);
    chk(expq.size() == 0, {tag, " R2 scoreboard drained"}, expq.size(), 0);
    chk(req_falls - r0 == nexp, {tag, " R3 request count"}, req_falls - r0, nexp);
    chk(!rma_sts, {tag, " R8 status untouched"}, rma_sts, 0);
    devsel_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_n && frame_n && irdy_n && !ad_oe && !done && !rma_sts, "R1 in reset",
        {req_n, frame_n, irdy_n, ad_oe, done, rma_sts}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_n && frame_n && irdy_n && !ad_oe && !done && !rma_sts, "R1 after reset",
        {req_n, frame_n, irdy_n, ad_oe, done, rma_sts}, 6'b111000);
    run_case(0, 1, 1, 1, 16'hA5C3, 0, "R2 sleep both");
    run_case(1, 0, 1, 1, 16'h1234, 0, "R3 nap halt");
    run_case(1, 0, 1, 0, 16'h5555, 0, "R4 nap masked");
    run_case(0, 1, 0, 1, 16'h0F0F, 0, "R4 sleep halt only");
    run_case(0, 1, 1, 0, 16'hBEEF, 0, "R4 sleep shutdown only");
    run_case(0, 1, 0, 0, 16'h7777, 0, "R4 sleep masked");
    run_case(1, 0, 0, 1, 16'h2468, 1, "R11 nap devsel");
    run_case(0, 1, 1, 1, 16'h8001, 1, "R11 sleep devsel");
    mabort_other = 1; @(negedge clk); mabort_other = 0;
    chk(rma_sts, "R8 other abort sets", rma_sts, 1);
    @(negedge clk);
    chk(rma_sts, "R8 flag holds", rma_sts, 1);
    rma_clr = 1; mabort_other = 1; @(negedge clk); rma_clr = 0; mabort_other = 0;
    chk(!rma_sts, "R8 clear wins", rma_sts, 0);
    run_case(0, 1, 1, 1, 16'hC0DE, 0, "R8 sleep after clear");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule